// File: doc/BRIEF.md
# Network Controller Suspend Sequencer

This block controls how a packet-DMA network controller goes into a quiet state and comes back out of it. Software asks for suspend with a control write. The block then watches status from the transmit and receive paths: DMA busy, a frame on the wire, and the number of packets held in the FIFOs and buffer memory. It turns off the start permissions for new DMA transfers and new frames. Once the chosen drain conditions are met, it reports that the controller is suspended.

The mode bit in the requesting write selects the entry policy. In fast entry, only work already in flight may finish, and packets may be left in the buffers. In full entry, started transmit DMA and started receive frames are allowed to finish. After that, every buffered transmit packet is sent and every buffered receive packet is moved to system memory. The block also keeps the descriptor ring positions so that work resumes where it stopped, and it holds a receive-demand flag that requests an immediate receive descriptor ring access.

All interfaces are plain control and status levels or single-cycle pulses. There is no valid/ready stream, and the block never applies back-pressure.

Top module: `suspend_seq`

## Requirements
- R1: After reset, `suspended`, `suspend_bit`, `fast_bit` and `rx_demand` are 0, both ring indices are 0, and all four start enables are 1.
- R2: A write with `wr_suspend`=1 and `wr_stop`=0, taken while `suspend_bit` is 0, drives `tx_dma_start_en` and `rx_frame_start_en` to 0 from the next cycle. With `wr_fast`=1, `rx_dma_start_en` and `tx_frame_start_en` also go to 0.
- R3: In fast entry, `suspended` rises one cycle after a clock edge at which `tx_dma_busy`, `rx_dma_busy`, `tx_on_wire` and `rx_on_wire` are all 0. Nonzero packet counts do not delay it.
- R4: During full entry, `tx_frame_start_en` and `rx_dma_start_en` stay 1, and `tx_dma_start_en` and `rx_frame_start_en` stay 0.
- R5: Full entry runs in two stages. It first waits for an edge with `tx_dma_busy`=0 and `rx_on_wire`=0. It then waits for an edge with both packet counts at 0 and both `tx_on_wire` and `rx_dma_busy` at 0. `suspended` goes high in the cycle after that second edge.
- R6: While `suspended` is 1, all four start enables are 0.
- R7: A write with `wr_suspend`=0 and `wr_stop`=0 clears `suspend_bit` and `fast_bit`. From the next cycle, `suspended` is 0 and all enables are 1. This also cancels an entry that is still in progress.
- R8: A write with `wr_stop`=1 clears `suspend_bit` and `fast_bit`, returns to running, and resets both ring indices to 0. Stop takes priority over `wr_suspend` in the same write.
- R9: A suspend request written while `suspend_bit` is already 1 is ignored. `fast_bit` and the drain progress are unchanged.
- R10: Each `*_desc_done` pulse advances its ring index by one, wrapping from RING_LEN-1 to 0. The indices are held across suspend entry and release.
- R11: A write with `wr_rx_demand`=1 sets `rx_demand`. Writing 0 leaves it unchanged. `rx_demand_ack` clears it, and a set in the same cycle wins over the clear.
- R12: `soft_rst`=1 at a clock edge returns every register to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| wr_en | input | 1 | Control write strobe |
| wr_suspend | input | 1 | Suspend field of the write |
| wr_fast | input | 1 | Entry mode field: 1 = fast, 0 = full |
| wr_stop | input | 1 | Stop field of the write |
| wr_rx_demand | input | 1 | Receive-demand field of the write |
| tx_dma_busy | input | 1 | Transmit DMA transfer in progress |
| rx_dma_busy | input | 1 | Receive DMA transfer in progress |
| tx_on_wire | input | 1 | Transmit frame being sent |
| rx_on_wire | input | 1 | Receive frame being received |
| tx_pkt_cnt | input | CNT_W | Transmit packets held in the FIFOs and buffer memory |
| rx_pkt_cnt | input | CNT_W | Receive packets held in the FIFOs and buffer memory |
| tx_desc_done | input | 1 | Transmit descriptor finished, advance ring |
| rx_desc_done | input | 1 | Receive descriptor finished, advance ring |
| rx_demand_ack | input | 1 | Buffer logic has taken the demanded ring access |
| tx_dma_start_en | output | 1 | New transmit DMA may start |
| rx_dma_start_en | output | 1 | New receive DMA may start |
| tx_frame_start_en | output | 1 | New transmit frame may start |
| rx_frame_start_en | output | 1 | New receive frame may start |
| suspended | output | 1 | Suspend reached |
| suspend_bit | output | 1 | Suspend control bit readback |
| fast_bit | output | 1 | Latched entry mode readback |
| rx_demand | output | 1 | Immediate receive ring access requested |
| tx_ring_idx | output | $clog2(RING_LEN) | Current transmit descriptor index |
| rx_ring_idx | output | $clog2(RING_LEN) | Current receive descriptor index |

## Verification
The assertions assume that hardware reset is asserted from time zero. They also assume that `soft_rst` is a clean synchronous level, so they are disabled while it is high. They place no constraint on the ordering of the busy and count inputs. The drain checks relate a rise of `suspended` only to input values sampled at the previous edge. The stimulus drives every input at the falling edge and holds it for a full cycle. It draws busy flags, counts and write fields freely from a seeded generator and compares each output against an independent cycle model in the bench. Stop writes and software resets are kept rare so that entries can finish.

// File: rtl/suspend_seq_pkg.sv
package suspend_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_DRAIN_ACT = 2'd1,
    ST_DRAIN_BUF = 2'd2,
    ST_SUSP      = 2'd3
  } susp_state_e;

  typedef struct packed {
    logic tx_dma;
    logic rx_dma;
    logic tx_frame;
    logic rx_frame;
  } start_gate_t;
endpackage

// File: rtl/suspend_seq_regs.sv
module suspend_seq_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic wr_en,
  input  logic wr_suspend,
  input  logic wr_fast,
  input  logic wr_stop,
  input  logic wr_rx_demand,
  input  logic rx_demand_ack,
  output logic susp_q,
  output logic fast_q,
  output logic demand_q,
  output logic req_take,
  output logic clr_susp,
  output logic ring_clr
);
  always_comb begin
    clr_susp = soft_rst | (wr_en & (wr_stop | ~wr_suspend));
    req_take = wr_en & wr_suspend & ~wr_stop & ~soft_rst & ~susp_q;
    ring_clr = soft_rst | (wr_en & wr_stop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_q <= 1'b0;
      fast_q <= 1'b0;
    end else if (clr_susp) begin
      susp_q <= 1'b0;
      fast_q <= 1'b0;
    end else if (req_take) begin
      susp_q <= 1'b1;
      fast_q <= wr_fast;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     demand_q <= 1'b0;
    else if (soft_rst)              demand_q <= 1'b0;
    else if (wr_en && wr_rx_demand) demand_q <= 1'b1;
    else if (rx_demand_ack)         demand_q <= 1'b0;
  end

  // R9: a repeated request must not disturb the latched mode
  assert_repeat_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (susp_q && wr_en && wr_suspend && !wr_stop) |=> (susp_q && $stable(fast_q)));

  // R11: a demand write always leaves the flag set
  assert_demand_set_R11: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (wr_en && wr_rx_demand) |=> demand_q);
endmodule

// File: rtl/suspend_seq_fsm.sv
module suspend_seq_fsm
  import suspend_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_susp,
  input  logic             req_take,
  input  logic             fast_q,
  input  logic             tx_dma_busy,
  input  logic             rx_dma_busy,
  input  logic             tx_on_wire,
  input  logic             rx_on_wire,
  input  logic [CNT_W-1:0] tx_pkt_cnt,
  input  logic [CNT_W-1:0] rx_pkt_cnt,
  output start_gate_t      gate,
  output logic             suspended
);
  susp_state_e state_q, state_d;
  logic inflight_idle, full_stage1_done, buffers_empty;

  always_comb begin
    inflight_idle    = ~(tx_dma_busy | rx_dma_busy | tx_on_wire | rx_on_wire);
    full_stage1_done = ~tx_dma_busy & ~rx_on_wire;
    buffers_empty    = (tx_pkt_cnt == '0) & (rx_pkt_cnt == '0) & ~tx_on_wire & ~rx_dma_busy;
  end

  always_comb begin
    state_d = state_q;
    if (clr_susp) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_q)
        ST_RUN:       if (req_take) state_d = ST_DRAIN_ACT;
        ST_DRAIN_ACT: begin
          if (fast_q) begin
            if (inflight_idle) state_d = ST_SUSP;
          end else if (full_stage1_done) begin
            state_d = ST_DRAIN_BUF;
          end
        end
        ST_DRAIN_BUF: if (buffers_empty) state_d = ST_SUSP;
        ST_SUSP:      state_d = ST_SUSP;
        default:      state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  always_comb begin
    gate = '{tx_dma: 1'b1, rx_dma: 1'b1, tx_frame: 1'b1, rx_frame: 1'b1};
    unique case (state_q)
      ST_RUN: ;
      ST_DRAIN_ACT, ST_DRAIN_BUF: begin
        gate.tx_dma   = 1'b0;
        gate.rx_frame = 1'b0;
        gate.rx_dma   = ~fast_q;
        gate.tx_frame = ~fast_q;
      end
      default: gate = '0;
    endcase
    suspended = (state_q == ST_SUSP);
  end

  // R5: the buffer stage is only reached in full entry
  assert_bufstage_full_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN_BUF) |-> !fast_q);
endmodule

// File: rtl/suspend_seq_ring.sv
module suspend_seq_ring #(
  parameter int RING_LEN = 16,
  localparam int IDX_W = (RING_LEN > 1) ? $clog2(RING_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(RING_LEN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (adv) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  // R10: the index never leaves the ring
  assert_idx_in_ring_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST);

  // R10: an advance without clear always moves the index
  assert_idx_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (idx != $past(idx)));
endmodule

// File: rtl/suspend_seq.sv
module suspend_seq
  import suspend_seq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int RING_LEN = 16,
  localparam int IDX_W   = (RING_LEN > 1) ? $clog2(RING_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic             wr_suspend,
  input  logic             wr_fast,
  input  logic             wr_stop,
  input  logic             wr_rx_demand,
  input  logic             tx_dma_busy,
  input  logic             rx_dma_busy,
  input  logic             tx_on_wire,
  input  logic             rx_on_wire,
  input  logic [CNT_W-1:0] tx_pkt_cnt,
  input  logic [CNT_W-1:0] rx_pkt_cnt,
  input  logic             tx_desc_done,
  input  logic             rx_desc_done,
  input  logic             rx_demand_ack,
  output logic             tx_dma_start_en,
  output logic             rx_dma_start_en,
  output logic             tx_frame_start_en,
  output logic             rx_frame_start_en,
  output logic             suspended,
  output logic             suspend_bit,
  output logic             fast_bit,
  output logic             rx_demand,
  output logic [IDX_W-1:0] tx_ring_idx,
  output logic [IDX_W-1:0] rx_ring_idx
);
  localparam int NCH = 2;

  logic        req_take, clr_susp, ring_clr;
  start_gate_t gate;
  logic [NCH-1:0] adv_v;
  logic [IDX_W-1:0] idx_v [NCH];

  suspend_seq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_en(wr_en), .wr_suspend(wr_suspend), .wr_fast(wr_fast),
    .wr_stop(wr_stop), .wr_rx_demand(wr_rx_demand), .rx_demand_ack(rx_demand_ack),
    .susp_q(suspend_bit), .fast_q(fast_bit), .demand_q(rx_demand),
    .req_take(req_take), .clr_susp(clr_susp), .ring_clr(ring_clr)
  );

  suspend_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .clr_susp(clr_susp), .req_take(req_take),
    .fast_q(fast_bit), .tx_dma_busy(tx_dma_busy), .rx_dma_busy(rx_dma_busy),
    .tx_on_wire(tx_on_wire), .rx_on_wire(rx_on_wire),
    .tx_pkt_cnt(tx_pkt_cnt), .rx_pkt_cnt(rx_pkt_cnt),
    .gate(gate), .suspended(suspended)
  );

  assign adv_v = {rx_desc_done, tx_desc_done};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ring
    suspend_seq_ring #(.RING_LEN(RING_LEN)) u_ring (
      .clk(clk), .rst_n(rst_n), .clr(ring_clr), .adv(adv_v[ch]), .idx(idx_v[ch])
    );
  end

  assign tx_ring_idx       = idx_v[0];
  assign rx_ring_idx       = idx_v[1];
  assign tx_dma_start_en   = gate.tx_dma;
  assign rx_dma_start_en   = gate.rx_dma;
  assign tx_frame_start_en = gate.tx_frame;
  assign rx_frame_start_en = gate.rx_frame;

  // R2: an accepted request shuts off new transmit DMA and new receive frames
  assert_request_gates_R2: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (wr_en && wr_suspend && !wr_stop && !suspend_bit) |=> (!tx_dma_start_en && !rx_frame_start_en));

  // R3: fast entry completes only on an edge with nothing in flight
  assert_fast_drained_R3: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    ($rose(suspended) && fast_bit) |->
      $past(!tx_dma_busy && !rx_dma_busy && !tx_on_wire && !rx_on_wire));

  // R5: full entry completes only on an edge with empty buffers
  assert_full_drained_R5: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    ($rose(suspended) && !fast_bit) |->
      $past(tx_pkt_cnt == '0 && rx_pkt_cnt == '0 && !tx_on_wire && !rx_dma_busy));

  // R6: nothing may start while suspended
  assert_suspended_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !(tx_dma_start_en || rx_dma_start_en || tx_frame_start_en || rx_frame_start_en));

  // R7: clearing the suspend bit releases everything in the next cycle
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (wr_en && !wr_suspend && !wr_stop) |=> (!suspended && !suspend_bit && tx_dma_start_en && rx_frame_start_en));

  // R8: stop clears the control bits and the ring positions
  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_stop) |=> (!suspend_bit && !fast_bit && tx_ring_idx == '0 && rx_ring_idx == '0));
endmodule

// File: tb/suspend_seq_tb_top.sv
`timescale 1ns/1ps
module suspend_seq_tb_top;
  localparam int CNT_W = 8;
  localparam int RING_LEN = 16;
  localparam int IDX_W = $clog2(RING_LEN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, wr_en = 0, wr_suspend = 0, wr_fast = 0, wr_stop = 0, wr_rx_demand = 0;
  logic tx_dma_busy = 0, rx_dma_busy = 0, tx_on_wire = 0, rx_on_wire = 0;
  logic [CNT_W-1:0] tx_pkt_cnt = '0, rx_pkt_cnt = '0;
  logic tx_desc_done = 0, rx_desc_done = 0, rx_demand_ack = 0;
  logic tx_dma_start_en, rx_dma_start_en, tx_frame_start_en, rx_frame_start_en;
  logic suspended, suspend_bit, fast_bit, rx_demand;
  logic [IDX_W-1:0] tx_ring_idx, rx_ring_idx;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  suspend_seq #(.CNT_W(CNT_W), .RING_LEN(RING_LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en), .wr_suspend(wr_suspend),
    .wr_fast(wr_fast), .wr_stop(wr_stop), .wr_rx_demand(wr_rx_demand),
    .tx_dma_busy(tx_dma_busy), .rx_dma_busy(rx_dma_busy), .tx_on_wire(tx_on_wire),
    .rx_on_wire(rx_on_wire), .tx_pkt_cnt(tx_pkt_cnt), .rx_pkt_cnt(rx_pkt_cnt),
    .tx_desc_done(tx_desc_done), .rx_desc_done(rx_desc_done), .rx_demand_ack(rx_demand_ack),
    .tx_dma_start_en(tx_dma_start_en), .rx_dma_start_en(rx_dma_start_en),
    .tx_frame_start_en(tx_frame_start_en), .rx_frame_start_en(rx_frame_start_en),
    .suspended(suspended), .suspend_bit(suspend_bit), .fast_bit(fast_bit),
    .rx_demand(rx_demand), .tx_ring_idx(tx_ring_idx), .rx_ring_idx(rx_ring_idx)
  );

  // Reference model; phase 0 run, 1 in-flight drain, 2 buffer drain, 3 suspended
  int m_phase = 0;
  logic m_susp = 0, m_fast = 0, m_dem = 0;
  int m_txi = 0, m_rxi = 0;

  function automatic logic [3:0] exp_gate(int phase, logic fast);
    // order {tx_dma, rx_dma, tx_frame, rx_frame}
    if (phase == 0) return 4'b1111;
    if (phase == 3) return 4'b0000;
    return fast ? 4'b0000 : 4'b0110;
  endfunction

  function automatic int next_idx(int i);
    return (i == RING_LEN - 1) ? 0 : i + 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0; m_susp <= 0; m_fast <= 0; m_dem <= 0; m_txi <= 0; m_rxi <= 0;
    end else if (soft_rst) begin
      m_phase <= 0; m_susp <= 0; m_fast <= 0; m_dem <= 0; m_txi <= 0; m_rxi <= 0;
    end else begin
      if (wr_en && wr_rx_demand) m_dem <= 1;
      else if (rx_demand_ack)    m_dem <= 0;
      if (wr_en && wr_stop) begin
        m_txi <= 0; m_rxi <= 0;
      end else begin
        if (tx_desc_done) m_txi <= next_idx(m_txi);
        if (rx_desc_done) m_rxi <= next_idx(m_rxi);
      end
      if (wr_en && (wr_stop || !wr_suspend)) begin
        m_susp <= 0; m_fast <= 0; m_phase <= 0;
      end else if (wr_en && wr_suspend && !m_susp) begin
        m_susp <= 1; m_fast <= wr_fast; m_phase <= 1;
      end else if (m_phase == 1) begin
        if (m_fast) begin
          if (!tx_dma_busy && !rx_dma_busy && !tx_on_wire && !rx_on_wire) m_phase <= 3;
        end else if (!tx_dma_busy && !rx_on_wire) m_phase <= 2;
      end else if (m_phase == 2) begin
        if (tx_pkt_cnt == 0 && rx_pkt_cnt == 0 && !tx_on_wire && !rx_dma_busy) m_phase <= 3;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk("R6 gates vs model", {tx_dma_start_en, rx_dma_start_en, tx_frame_start_en, rx_frame_start_en},
        exp_gate(m_phase, m_fast));
    chk("R5 suspended vs model", suspended, (m_phase == 3));
    chk("R9 suspend_bit vs model", suspend_bit, m_susp);
    chk("R9 fast_bit vs model", fast_bit, m_fast);
    chk("R11 rx_demand vs model", rx_demand, m_dem);
    chk("R10 ring idx vs model", {tx_ring_idx, rx_ring_idx}, (m_txi << IDX_W) | m_rxi);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write(input logic s, input logic f, input logic st, input logic d);
    wr_en = 1; wr_suspend = s; wr_fast = f; wr_stop = st; wr_rx_demand = d;
    tick();
    wr_en = 0; wr_suspend = 0; wr_fast = 0; wr_stop = 0; wr_rx_demand = 0;
  endtask

  task automatic idle_inputs();
    tx_dma_busy = 0; rx_dma_busy = 0; tx_on_wire = 0; rx_on_wire = 0;
    tx_pkt_cnt = 0; rx_pkt_cnt = 0; tx_desc_done = 0; rx_desc_done = 0; rx_demand_ack = 0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 suspended", suspended, 0);
    chk("R1 enables", {tx_dma_start_en, rx_dma_start_en, tx_frame_start_en, rx_frame_start_en}, 15);
    chk("R1 bits", {suspend_bit, fast_bit, rx_demand}, 0);
    chk("R1 ring", {tx_ring_idx, rx_ring_idx}, 0);

    // Fast entry held by a transmit frame on the wire
    tx_on_wire = 1;
    write(1, 1, 0, 0);
    chk("R2 fast gates closed", {tx_dma_start_en, rx_dma_start_en, tx_frame_start_en, rx_frame_start_en}, 0);
    write(1, 0, 0, 0);
    chk("R9 fast_bit kept", fast_bit, 1);
    chk("R9 tx_frame still blocked", tx_frame_start_en, 0);
    tick();
    chk("R3 waits for wire", suspended, 0);
    tx_on_wire = 0; tx_pkt_cnt = 5; rx_pkt_cnt = 2;
    tick();
    chk("R3 suspended with packets left", suspended, 1);
    chk("R6 gates while suspended", {tx_dma_start_en, rx_dma_start_en, tx_frame_start_en, rx_frame_start_en}, 0);
    write(0, 0, 0, 0);
    chk("R7 released", suspended, 0);
    chk("R7 enables back", {tx_dma_start_en, rx_dma_start_en, tx_frame_start_en, rx_frame_start_en}, 15);

    // Full entry
    tx_pkt_cnt = 2; rx_pkt_cnt = 1; tx_dma_busy = 1;
    write(1, 0, 0, 0);
    chk("R4 full gates", {tx_dma_start_en, rx_dma_start_en, tx_frame_start_en, rx_frame_start_en}, 6);
    tick();
    tx_dma_busy = 0;
    tick(); tick(); tick();
    chk("R5 held by buffered packets", suspended, 0);
    chk("R4 full gates in buffer stage", {tx_frame_start_en, rx_dma_start_en}, 3);
    tx_pkt_cnt = 0; rx_pkt_cnt = 0;
    tick();
    chk("R5 suspended after flush", suspended, 1);
    // Cancel during entry
    write(0, 0, 0, 0);
    rx_on_wire = 1;
    write(1, 1, 0, 0);
    write(0, 1, 0, 0);
    chk("R7 cancel mid-entry", {suspended, suspend_bit, fast_bit}, 0);
    rx_on_wire = 0;

    // Ring wrap and hold across suspend
    tx_desc_done = 1;
    repeat (17) tick();
    tx_desc_done = 0; rx_desc_done = 1;
    repeat (3) tick();
    rx_desc_done = 0;
    chk("R10 tx wrap", tx_ring_idx, 1);
    chk("R10 rx advance", rx_ring_idx, 3);
    write(1, 1, 0, 0);
    tick();
    chk("R3 idle fast entry", suspended, 1);
    write(0, 0, 0, 0);
    chk("R10 held across suspend", {tx_ring_idx, rx_ring_idx}, (1 << IDX_W) | 3);

    // Stop wins over suspend
    write(1, 1, 1, 0);
    chk("R8 stop bits", {suspend_bit, fast_bit, suspended}, 0);
    chk("R8 ring reset", {tx_ring_idx, rx_ring_idx}, 0);

    // Receive demand
    rx_demand_ack = 1;
    write(0, 0, 0, 1);
    rx_demand_ack = 0;
    chk("R11 set beats ack", rx_demand, 1);
    write(0, 0, 0, 0);
    chk("R11 write 0 no effect", rx_demand, 1);
    rx_demand_ack = 1; tick(); rx_demand_ack = 0;
    chk("R11 ack clears", rx_demand, 0);

    // Software reset
    tx_desc_done = 1; tick(); tx_desc_done = 0;
    write(1, 0, 0, 1);
    soft_rst = 1; tick(); soft_rst = 0;
    chk("R12 soft reset", {suspend_bit, fast_bit, rx_demand, suspended}, 0);
    chk("R12 soft reset ring", tx_ring_idx, 0);
    cmp_model();

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      wr_en        = ($urandom % 8) == 0;
      wr_suspend   = ($urandom % 3) != 0;
      wr_fast      = $urandom % 2;
      wr_stop      = ($urandom % 16) == 0;
      wr_rx_demand = ($urandom % 4) == 0;
      tx_dma_busy  = ($urandom % 4) == 0;
      rx_dma_busy  = ($urandom % 4) == 0;
      tx_on_wire   = ($urandom % 4) == 0;
      rx_on_wire   = ($urandom % 4) == 0;
      tx_pkt_cnt   = (($urandom % 2) == 0) ? '0 : CNT_W'($urandom % 4);
      rx_pkt_cnt   = (($urandom % 2) == 0) ? '0 : CNT_W'($urandom % 4);
      tx_desc_done = ($urandom % 4) == 0;
      rx_desc_done = ($urandom % 4) == 0;
      rx_demand_ack = ($urandom % 4) == 0;
      soft_rst     = ($urandom % 500) == 0;
      tick();
      cmp_model();
    end
    wr_en = 0; soft_rst = 0;
    idle_inputs();
    tick();
    cmp_model();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule